// File: doc/BRIEF.md
# Integer Operate-Format Execution Unit

This unit executes one register-to-register integer instruction per clock on a 64-bit datapath. Each instruction is a 32-bit operate-format word. The unit decodes the word and picks the second operand. That operand is either the value read for the rb register or an 8-bit literal taken from the word and zero-extended. The unit then computes an add or subtract, an add or subtract with the first operand scaled by 4 or 8, a signed less-than compare, or a conditional move.

The register file lives outside the unit. The surrounding pipeline reads the two source registers named by the word and presents their values next to the word, along with a valid strobe. One cycle later the unit returns three things: the destination index, the 64-bit result and a write enable. The write enable is held low in three cases:
- the test of a conditional move fails;
- the destination is register 31;
- the word is not a legal operate instruction. In this case an illegal flag is raised instead.

Top module: `int_op_unit`

## Requirements
- R1: While reset is asserted and in the first cycle after it, out_valid, out_we and out_illegal are low, and out_result and out_rc are zero.
- R2: A word presented with in_valid high in one cycle gives out_valid high in the next cycle, with out_rc equal to bits 4:0 of that word. A cycle with in_valid low gives out_valid, out_we and out_illegal low in the next cycle.
- R3: Bit 12 of the word picks the second operand. When it is 0, the operand is rb_val, and bits 15:13 of the word are ignored. When it is 1, the operand is bits 20:13 of the word, zero-extended to 64 bits.
- R4: A source index of 31 reads as zero. This applies to the ra index in bits 25:21 and, when bit 12 is 0, to the rb index in bits 20:16. The value on the matching input is then ignored.
- R5: Function code 0x00 (bits 11:5) gives ra + op2. Code 0x09 gives ra − op2. Both are taken modulo 2^64.
- R6: The scaled forms are taken modulo 2^64: code 0x02 gives 4·ra + op2, code 0x12 gives 8·ra + op2, code 0x0B gives 4·ra − op2, and code 0x1B gives 8·ra − op2.
- R7: Code 0x4D gives 1 when ra is less than op2 as signed 64-bit numbers, and 0 otherwise.
- R8: The conditional moves always return op2 as the result. The write enable is high only when the test on ra holds: code 0x24 needs ra == 0, code 0x26 needs ra != 0, and code 0x46 needs ra ≥ 0 as a signed number.
- R9: A destination index of 31 in bits 4:0 forces out_we low for every function.
- R10: The word is illegal when its opcode in bits 31:26 is not 0x10, or when its function code is not one of the ten codes listed above. An illegal word gives out_illegal high, out_we low and a result of zero.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| in_valid | input | 1 | Instruction word and operands are valid this cycle |
| instr | input | 32 | Operate-format instruction word |
| ra_val | input | 64 | Value read for the ra index |
| rb_val | input | 64 | Value read for the rb index |
| out_valid | output | 1 | Result outputs are valid |
| out_rc | output | 5 | Destination register index |
| out_result | output | 64 | Computed result |
| out_we | output | 1 | Write the result to out_rc |
| out_illegal | output | 1 | The word was not a legal operate instruction |

## Verification
The bench goes after the boundaries of each operation:
- A literal of 255 must come out as 0xFF and not as −1. A sign-extending design would fail this.
- Subtracts and scaled forms must wrap past 2^64. A design that lost the scaled carries or used the wrong shift would give a wrong result here.
- The compare must treat the most negative value as less than 0. A design that compared unsigned would get this wrong.
- Conditional moves with ra at zero, one and the sign boundary must still return op2 while withholding the write enable. A design that wrote back the old value, or always wrote, would fail these cases.
- Index 31 must read as zero at either source and block the write when it is the destination.
- An unknown function code or opcode must raise the illegal flag and block the write.

Random words drawn from the legal codes, mixed with arbitrary codes, also exercise back-to-back issue and idle gaps.

// File: rtl/int_op_unit.sv
module int_op_unit #(
  parameter int XLEN   = 64,
  parameter int IW     = 32,
  parameter int RIDX   = 5,
  parameter int LITW   = 8,
  parameter logic [5:0] OPC_OP = 6'h10
) (
  input  logic            clk,
  input  logic            rst_n,
  input  logic            in_valid,
  input  logic [IW-1:0]   instr,
  input  logic [XLEN-1:0] ra_val,
  input  logic [XLEN-1:0] rb_val,
  output logic            out_valid,
  output logic [RIDX-1:0] out_rc,
  output logic [XLEN-1:0] out_result,
  output logic            out_we,
  output logic            out_illegal
);
  localparam logic [RIDX-1:0] ZREG = {RIDX{1'b1}};

  localparam logic [6:0] F_ADD   = 7'h00;
  localparam logic [6:0] F_SUB   = 7'h09;
  localparam logic [6:0] F_S4ADD = 7'h02;
  localparam logic [6:0] F_S8ADD = 7'h12;
  localparam logic [6:0] F_S4SUB = 7'h0B;
  localparam logic [6:0] F_S8SUB = 7'h1B;
  localparam logic [6:0] F_CMPLT = 7'h4D;
  localparam logic [6:0] F_CMOVEQ = 7'h24;
  localparam logic [6:0] F_CMOVNE = 7'h26;
  localparam logic [6:0] F_CMOVGE = 7'h46;

  logic [5:0]      opc;
  logic [RIDX-1:0] ra_idx, rb_idx, rc_idx;
  logic            use_lit;
  logic [6:0]      func;
  logic [LITW-1:0] lit;

  assign opc     = instr[31:26];
  assign ra_idx  = instr[25:21];
  assign rb_idx  = instr[20:16];
  assign lit     = instr[20:13];
  assign use_lit = instr[12];
  assign func    = instr[11:5];
  assign rc_idx  = instr[4:0];

  logic [XLEN-1:0] opa, opb, opa4, opa8;

  assign opa  = (ra_idx == ZREG) ? '0 : ra_val;
  assign opb  = use_lit ? {{(XLEN-LITW){1'b0}}, lit}
                        : ((rb_idx == ZREG) ? '0 : rb_val);
  assign opa4 = opa << 2;
  assign opa8 = opa << 3;

  logic [XLEN-1:0] res;
  logic            cond, legal;

  always_comb begin
    res   = '0;
    cond  = 1'b1;
    legal = (opc == OPC_OP);
    case (func)
      F_ADD:    res = opa + opb;
      F_SUB:    res = opa - opb;
      F_S4ADD:  res = opa4 + opb;
      F_S8ADD:  res = opa8 + opb;
      F_S4SUB:  res = opa4 - opb;
      F_S8SUB:  res = opa8 - opb;
      F_CMPLT:  res = {{(XLEN-1){1'b0}}, ($signed(opa) < $signed(opb))};
      F_CMOVEQ: begin res = opb; cond = (opa == '0); end
      F_CMOVNE: begin res = opb; cond = (opa != '0); end
      F_CMOVGE: begin res = opb; cond = ~opa[XLEN-1]; end
      default:  legal = 1'b0;
    endcase
    if (!legal) res = '0;
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      out_valid   <= 1'b0;
      out_rc      <= '0;
      out_result  <= '0;
      out_we      <= 1'b0;
      out_illegal <= 1'b0;
    end else begin
      out_valid   <= in_valid;
      out_we      <= in_valid && legal && cond && (rc_idx != ZREG);
      out_illegal <= in_valid && !legal;
      if (in_valid) begin
        out_rc     <= rc_idx;
        out_result <= res;
      end
    end
  end
endmodule

// File: rtl/int_op_unit_chk.sv
module int_op_unit_chk #(
  parameter int XLEN = 64,
  parameter int IW   = 32,
  parameter int RIDX = 5
) (
  input logic            clk,
  input logic            rst_n,
  input logic            in_valid,
  input logic [IW-1:0]   instr,
  input logic            out_valid,
  input logic [RIDX-1:0] out_rc,
  input logic [XLEN-1:0] out_result,
  input logic            out_we,
  input logic            out_illegal
);
  assert_valid_follows_R2: assert property (@(posedge clk) disable iff (!rst_n)
    in_valid |=> out_valid);
  assert_idle_follows_R2: assert property (@(posedge clk) disable iff (!rst_n)
    !in_valid |=> (!out_valid && !out_we && !out_illegal));
  assert_rc_echo_R2: assert property (@(posedge clk) disable iff (!rst_n)
    in_valid |=> (out_rc == $past(instr[4:0])));
  assert_we_needs_valid_R8: assert property (@(posedge clk) disable iff (!rst_n)
    out_we |-> out_valid);
  assert_rc31_no_write_R9: assert property (@(posedge clk) disable iff (!rst_n)
    (out_valid && out_rc == {RIDX{1'b1}}) |-> !out_we);
  assert_illegal_no_write_R10: assert property (@(posedge clk) disable iff (!rst_n)
    out_illegal |-> (!out_we && out_result == '0));
  assert_cmplt_boolean_R7: assert property (@(posedge clk) disable iff (!rst_n)
    (in_valid && instr[31:26] == 6'h10 && instr[11:5] == 7'h4D)
      |=> (out_result[XLEN-1:1] == '0));
endmodule

bind int_op_unit int_op_unit_chk #(.XLEN(XLEN), .IW(IW), .RIDX(RIDX)) u_chk (
  .clk(clk), .rst_n(rst_n), .in_valid(in_valid), .instr(instr),
  .out_valid(out_valid), .out_rc(out_rc), .out_result(out_result),
  .out_we(out_we), .out_illegal(out_illegal)
);

// File: tb/int_op_unit_tb.sv
`timescale 1ns/1ps
module int_op_unit_tb;
  logic        clk = 1'b0;
  logic        rst_n;
  logic        in_valid;
  logic [31:0] instr;
  logic [63:0] ra_val, rb_val;
  logic        out_valid, out_we, out_illegal;
  logic [4:0]  out_rc;
  logic [63:0] out_result;

  int checks = 0;
  int errors = 0;
  bit done = 0;

  always #4 clk = ~clk;

  int_op_unit u_dut (
    .clk(clk), .rst_n(rst_n), .in_valid(in_valid), .instr(instr),
    .ra_val(ra_val), .rb_val(rb_val), .out_valid(out_valid), .out_rc(out_rc),
    .out_result(out_result), .out_we(out_we), .out_illegal(out_illegal)
  );

  function automatic logic [31:0] mk_r(input logic [4:0] ra, input logic [4:0] rb,
                                       input logic [6:0] fn, input logic [4:0] rc);
    return {6'h10, ra, rb, 3'b000, 1'b0, fn, rc};
  endfunction

  function automatic logic [31:0] mk_l(input logic [4:0] ra, input logic [7:0] lit,
                                       input logic [6:0] fn, input logic [4:0] rc);
    return {6'h10, ra, lit, 1'b1, fn, rc};
  endfunction

  task automatic model(input logic [31:0] w, input logic [63:0] a_in, input logic [63:0] b_in,
                       output logic [63:0] r, output logic we, output logic ill);
    logic [63:0] a, b;
    logic ok;
    a  = (w[25:21] == 5'd31) ? 64'd0 : a_in;
    b  = w[12] ? {56'd0, w[20:13]} : ((w[20:16] == 5'd31) ? 64'd0 : b_in);
    ok = 1'b1;
    we = 1'b1;
    r  = 64'd0;
    case (w[11:5])
      7'h00: r = a + b;
      7'h09: r = a - b;
      7'h02: r = a * 64'd4 + b;
      7'h12: r = a * 64'd8 + b;
      7'h0B: r = a * 64'd4 - b;
      7'h1B: r = a * 64'd8 - b;
      7'h4D: r = ($signed(a) < $signed(b)) ? 64'd1 : 64'd0;
      7'h24: begin r = b; we = (a == 64'd0); end
      7'h26: begin r = b; we = (a != 64'd0); end
      7'h46: begin r = b; we = ($signed(a) >= 0); end
      default: ok = 1'b0;
    endcase
    if (w[31:26] != 6'h10) ok = 1'b0;
    if (!ok) begin r = 64'd0; we = 1'b0; end
    if (w[4:0] == 5'd31) we = 1'b0;
    ill = !ok;
  endtask

  task automatic chk(input string req, input string what, input logic [63:0] act,
                     input logic [63:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s %s: actual=%h expected=%h", req, what, act, exp);
    end
  endtask

  task automatic run(input string req, input logic [31:0] w, input logic [63:0] a,
                     input logic [63:0] b);
    logic [63:0] er;
    logic ew, ei;
    model(w, a, b, er, ew, ei);
    in_valid = 1'b1; instr = w; ra_val = a; rb_val = b;
    @(negedge clk);
    chk(req, "valid", {63'd0, out_valid}, 64'd1);
    chk(req, "rc", {59'd0, out_rc}, {59'd0, w[4:0]});
    chk(req, "result", out_result, er);
    chk(req, "we", {63'd0, out_we}, {63'd0, ew});
    chk(req, "illegal", {63'd0, out_illegal}, {63'd0, ei});
  endtask

  task automatic idle();
    in_valid = 1'b0; instr = $urandom; ra_val = {$urandom, $urandom}; rb_val = {$urandom, $urandom};
    @(negedge clk);
    chk("R2", "idle valid", {63'd0, out_valid}, 64'd0);
    chk("R2", "idle we", {63'd0, out_we}, 64'd0);
    chk("R2", "idle illegal", {63'd0, out_illegal}, 64'd0);
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    if (!done) begin
      errors++; checks++;
      $display("FAIL watchdog: actual=timeout expected=finish");
      $display("Result: errors=%0d of %0d checks", errors, checks);
      $finish;
    end
  end

  localparam logic [6:0] FN [10] = '{7'h00, 7'h09, 7'h02, 7'h12, 7'h0B,
                                     7'h1B, 7'h4D, 7'h24, 7'h26, 7'h46};

  initial begin
    logic [63:0] neg_min;
    neg_min = 64'h8000_0000_0000_0000;
    void'($urandom(32'd1234));
    rst_n = 1'b0; in_valid = 1'b0; instr = '0; ra_val = '0; rb_val = '0;
    repeat (3) @(negedge clk);
    chk("R1", "reset valid", {63'd0, out_valid}, 64'd0);
    chk("R1", "reset we", {63'd0, out_we}, 64'd0);
    chk("R1", "reset illegal", {63'd0, out_illegal}, 64'd0);
    chk("R1", "reset result", out_result, 64'd0);
    chk("R1", "reset rc", {59'd0, out_rc}, 64'd0);
    rst_n = 1'b1;
    @(negedge clk);
    chk("R1", "post-reset valid", {63'd0, out_valid}, 64'd0);

    run("R5", mk_r(5'd1, 5'd2, 7'h00, 5'd3), 64'd10, 64'd32);
    run("R5", mk_r(5'd1, 5'd2, 7'h09, 5'd3), 64'd5, 64'd7);
    run("R5", mk_r(5'd1, 5'd2, 7'h00, 5'd4), 64'hFFFF_FFFF_FFFF_FFFF, 64'd1);
    run("R3", mk_l(5'd1, 8'hFF, 7'h00, 5'd5), 64'd1, 64'hDEAD);
    run("R3", {6'h10, 5'd1, 5'd2, 3'b111, 1'b0, 7'h00, 5'd6}, 64'd3, 64'd4);
    run("R4", mk_r(5'd31, 5'd2, 7'h00, 5'd7), 64'h1234, 64'd9);
    run("R4", mk_r(5'd1, 5'd31, 7'h09, 5'd7), 64'd9, 64'h5555);
    run("R6", mk_r(5'd1, 5'd2, 7'h02, 5'd8), 64'd3, 64'd1);
    run("R6", mk_r(5'd1, 5'd2, 7'h12, 5'd8), 64'd3, 64'd1);
    run("R6", mk_l(5'd1, 8'd20, 7'h0B, 5'd8), 64'd3, 64'd0);
    run("R6", mk_r(5'd1, 5'd2, 7'h1B, 5'd8), 64'h4000_0000_0000_0001, 64'd9);
    run("R7", mk_r(5'd1, 5'd2, 7'h4D, 5'd9), neg_min, 64'd0);
    run("R7", mk_r(5'd1, 5'd2, 7'h4D, 5'd9), 64'd0, neg_min);
    run("R7", mk_r(5'd1, 5'd2, 7'h4D, 5'd9), 64'd5, 64'd5);
    run("R8", mk_l(5'd1, 8'd4, 7'h24, 5'd10), 64'd0, 64'd0);
    run("R8", mk_l(5'd1, 8'd4, 7'h24, 5'd10), 64'd1, 64'd0);
    run("R8", mk_r(5'd1, 5'd2, 7'h26, 5'd10), 64'd0, 64'h77);
    run("R8", mk_r(5'd1, 5'd2, 7'h26, 5'd10), 64'd2, 64'h77);
    run("R8", mk_r(5'd1, 5'd2, 7'h46, 5'd10), neg_min, 64'h99);
    run("R8", mk_r(5'd1, 5'd2, 7'h46, 5'd10), 64'd0, 64'h99);
    run("R9", mk_r(5'd1, 5'd2, 7'h00, 5'd31), 64'd1, 64'd1);
    run("R10", mk_r(5'd1, 5'd2, 7'h7F, 5'd11), 64'd1, 64'd1);
    run("R10", {6'h11, 5'd1, 5'd2, 3'b000, 1'b0, 7'h00, 5'd11}, 64'd1, 64'd1);
    idle();
    run("R2", mk_r(5'd1, 5'd2, 7'h00, 5'd12), 64'd1, 64'd1);

    for (int i = 0; i < 3000; i++) begin
      logic [31:0] w;
      logic [63:0] a, b;
      logic [6:0] fn;
      fn = ($urandom % 8 == 0) ? 7'($urandom) : FN[$urandom % 10];
      w = $urandom;
      w[31:26] = ($urandom % 16 == 0) ? 6'($urandom) : 6'h10;
      w[11:5] = fn;
      a = {$urandom, $urandom};
      b = {$urandom, $urandom};
      case ($urandom % 4)
        0: a = 64'd0;
        1: a = {$urandom % 2 == 0 ? 32'hFFFF_FFFF : 32'd0, $urandom};
        default: ;
      endcase
      if ($urandom % 6 == 0) idle();
      else run("R2", w, a, b);
    end

    done = 1;
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end
endmodule